// File: doc/BRIEF.md
# AUX Request Header Framer

This block turns one auxiliary-channel request into the ordered byte stream handed to a link-level transmitter. A request carries a 4-bit command, a 20-bit address, a payload length, a write/read flag, a device-address flag for I2C-over-AUX traffic, a start delay and up to `MAX_LEN` payload bytes on a flat bus. The block captures the request and acknowledges any stale completion indication from the transmitter. It waits until that indication is low, pulses a go strobe and waits a programmable number of cycles. It then streams the header and, for writes only, the payload over a valid/ready byte interface.

The header is three bytes when the length is zero and four bytes when the length is non-zero. For I2C-over-AUX requests the address is shifted right by one before framing, so an 8-bit device address becomes its 7-bit form. The total byte count is published as soon as the request is accepted and stays stable until the next one. A request whose length exceeds `MAX_LEN` is refused: it raises a one-cycle error flag and produces no strobe and no bytes.

Top module: `aux_hdr_framer`

## Requirements
- R1: The first streamed byte is the command in bits [7:4] with address bits [19:16] in bits [3:0].
- R2: The second byte is address bits [15:8] and the third byte is address bits [7:0].
- R3: When the length is non-zero, a fourth byte equal to length minus one follows the address bytes. A zero length gives a three-byte header.
- R4: When the write flag is 1, payload bytes follow the header, payload byte 0 (bits [7:0] of the payload bus) first. When the write flag is 0, no payload is sent.
- R5: `tx_count` equals the header size (3 or 4) plus the length for writes. It is valid from the cycle after acceptance, and exactly that many bytes are handed off.
- R6: When the I2C flag is 1, the framed address is the request address shifted right by one bit.
- R7: In the cycle after acceptance, `done_ack` is high for exactly one cycle. `go` is high for one cycle only when `done_in` is low, and never before that acknowledge.
- R8: The first byte is valid `req_dly + 1` cycles after the cycle in which `go` is high.
- R9: A request with a length above `MAX_LEN` pulses `err` in the next cycle, leaves `req_ready` high, and produces no `go` and no bytes.
- R10: `req_ready` is low from acceptance of a legal request until the cycle after the last byte handshake.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Address (8-bit device address in I2C mode) |
| req_len | input | $clog2(MAX_LEN+1) | Payload length in bytes |
| req_write | input | 1 | 1 = write (payload sent), 0 = read |
| req_i2c | input | 1 | 1 = I2C-over-AUX request (address shifted right) |
| req_dly | input | DLY_W | Start delay in cycles after go |
| req_payload | input | MAX_LEN*8 | Payload bytes, byte i in bits [8i+7:8i] |
| done_in | input | 1 | Completion indication from the transmitter |
| done_ack | output | 1 | Acknowledge of the completion indication |
| go | output | 1 | Launch strobe |
| tx_count | output | $clog2(MAX_LEN+5) | Total bytes of the current request |
| err | output | 1 | Length-rejection pulse |
| out_valid | output | 1 | Byte valid |
| out_ready | input | 1 | Transmitter takes the byte |
| out_data | output | 8 | Streamed byte |

## Verification
The bench keeps the default `MAX_LEN` of 16 and `DLY_W` of 8. The length port is therefore 5 bits wide, so lengths 17 to 31 can be driven to exercise rejection, alongside the legal boundaries 0, 1 and 16. The 8-bit delay allows both a zero delay and a long delay of 20 cycles. Random backpressure and random hold times on `done_in` test the hold and launch-order rules in every random request.

// File: rtl/aux_hdr_framer.sv
module aux_hdr_framer #(
  parameter int MAX_LEN = 16,
  parameter int DLY_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [3:0]             req_cmd,
  input  logic [19:0]            req_addr,
  input  logic [$clog2(MAX_LEN+1)-1:0] req_len,
  input  logic                   req_write,
  input  logic                   req_i2c,
  input  logic [DLY_W-1:0]       req_dly,
  input  logic [MAX_LEN*8-1:0]   req_payload,
  input  logic                   done_in,
  output logic                   done_ack,
  output logic                   go,
  output logic [$clog2(MAX_LEN+5)-1:0] tx_count,
  output logic                   err,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data
);
  localparam int LEN_W = $clog2(MAX_LEN+1);
  localparam int CNT_W = $clog2(MAX_LEN+5);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_WAIT, S_DLY, S_SEND} st_t;

  st_t              st;
  logic [3:0]       cmd_q;
  logic [19:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [DLY_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx_q, tot_q;
  logic             err_q;
  logic [7:0]       pay_q [MAX_LEN];

  logic             accept, len_ok;
  logic [CNT_W-1:0] req_tot, hdr_q, pidx;
  logic [7:0]       pbyte;

  assign accept  = req_valid && st == S_IDLE;
  assign len_ok  = req_len <= LEN_W'(MAX_LEN);
  assign req_tot = ((req_len != '0) ? CNT_W'(4) : CNT_W'(3)) +
                   (req_write ? CNT_W'(req_len) : '0);
  assign hdr_q   = (len_q != '0) ? CNT_W'(4) : CNT_W'(3);
  assign pidx    = idx_q - hdr_q;

  assign req_ready = st == S_IDLE;
  assign done_ack  = st == S_ACK;
  assign go        = st == S_WAIT && !done_in;
  assign out_valid = st == S_SEND;
  assign tx_count  = tot_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      tot_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (!len_ok) err_q <= 1'b1;
          else begin
            cmd_q  <= req_cmd;
            addr_q <= req_i2c ? (req_addr >> 1) : req_addr;
            len_q  <= req_len;
            cnt_q  <= req_dly;
            idx_q  <= '0;
            tot_q  <= req_tot;
            st     <= S_ACK;
          end
        end
        S_ACK:  st <= S_WAIT;
        S_WAIT: if (!done_in) st <= (cnt_q == '0) ? S_SEND : S_DLY;
        S_DLY: begin
          cnt_q <= cnt_q - DLY_W'(1);
          if (cnt_q == DLY_W'(1)) st <= S_SEND;
        end
        S_SEND: if (out_ready) begin
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q == tot_q - CNT_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && len_ok)
      for (int i = 0; i < MAX_LEN; i++) pay_q[i] <= req_payload[8*i +: 8];
  end

  always_comb begin
    pbyte = 8'h00;
    for (int i = 0; i < MAX_LEN; i++)
      if (pidx == CNT_W'(i)) pbyte = pay_q[i];
  end

  always_comb begin
    if (idx_q == CNT_W'(0))      out_data = {cmd_q, addr_q[19:16]};
    else if (idx_q == CNT_W'(1)) out_data = addr_q[15:8];
    else if (idx_q == CNT_W'(2)) out_data = addr_q[7:0];
    else if (idx_q == CNT_W'(3) && len_q != '0) out_data = 8'(len_q) - 8'd1;
    else                         out_data = pbyte;
  end
endmodule

// File: rtl/aux_hdr_framer_chk.sv
module aux_hdr_framer_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             go,
  input logic             done_in,
  input logic             done_ack,
  input logic             err,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic [CNT_W-1:0] tx_count
);
  logic [CNT_W-1:0] sent;
  logic             ack_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent     <= '0;
      ack_seen <= 1'b0;
    end else begin
      if (go) sent <= '0;
      else if (out_valid && out_ready) sent <= sent + CNT_W'(1);
      if (done_ack) ack_seen <= 1'b1;
      else if (go) ack_seen <= 1'b0;
    end
  end

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  p_go_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !done_in);
  p_go_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ack_seen);
  p_go_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_no_extra_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> sent < tx_count);
  p_all_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> sent == tx_count);
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (req_ready && !out_valid && !go));
endmodule

bind aux_hdr_framer aux_hdr_framer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .go(go),
  .done_in(done_in), .done_ack(done_ack), .err(err),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .tx_count(tx_count)
);

// File: tb/aux_hdr_framer_test.sv
module aux_hdr_framer_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_i2c = 0, done_in = 0, out_ready = 0;
  logic [3:0] req_cmd = 0;
  logic [19:0] req_addr = 0;
  logic [4:0] req_len = 0;
  logic [7:0] req_dly = 0;
  logic [127:0] req_payload = 0;
  logic req_ready, done_ack, go, err, out_valid;
  logic [4:0] tx_count;
  logic [7:0] out_data;
  int checks = 0, errors = 0;

  aux_hdr_framer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .req_write(req_write), .req_i2c(req_i2c), .req_dly(req_dly),
    .req_payload(req_payload), .done_in(done_in), .done_ack(done_ack),
    .go(go), .tx_count(tx_count), .err(err), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_total(input int len, input bit wr);
    return (len != 0 ? 4 : 3) + (wr ? len : 0);
  endfunction

  function automatic logic [7:0] exp_byte(input int idx, input logic [3:0] cmd,
      input logic [19:0] a, input int len, input logic [127:0] pay);
    int h = (len != 0) ? 4 : 3;
    if (idx == 0) return {cmd, a[19:16]};
    if (idx == 1) return a[15:8];
    if (idx == 2) return a[7:0];
    if (idx == 3 && len != 0) return 8'(len - 1);
    return pay[(idx-h)*8 +: 8];
  endfunction

  function automatic string byte_tag(input int idx, input int len, input bit i2c);
    string t;
    if (idx == 0) t = "R1";
    else if (idx < 3) t = "R2";
    else if (idx == 3 && len != 0) t = "R3";
    else t = "R4";
    return i2c ? {t, "/R6"} : t;
  endfunction

  task automatic run_req(input logic [3:0] cmd, input logic [19:0] addr, input int len,
      input bit wr, input bit i2c, input int dly, input logic [127:0] pay,
      input int hold, input bit done_start);
    logic [19:0] ae = i2c ? (addr >> 1) : addr;
    int total = exp_total(len, wr);
    int ack_c = -1, go_c = -1, first_c = -1, gos = 0, nb = 0, cyc = 1;
    bit held = 0;
    logic [7:0] held_d = 0;
    done_in = done_start;
    @(negedge clk);
    req_cmd = cmd; req_addr = addr; req_len = 5'(len); req_write = wr;
    req_i2c = i2c; req_dly = 8'(dly); req_payload = pay; req_valid = 1;
    out_ready = 0;
    #1 chk(req_ready == 1, "R10 idle ready", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    #1;
    if (len > 16) begin
      chk(err == 1 && req_ready == 1, "R9 reject flag", {err, req_ready}, 3);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); out_ready = 1; #1;
        chk(!out_valid && !go && !done_ack && req_ready, "R9 no activity",
            {out_valid, go, done_ack, req_ready}, 1);
      end
      return;
    end
    chk(req_ready == 0, "R10 busy after accept", req_ready, 0);
    chk(done_ack == 1, "R7 ack after accept", done_ack, 1);
    chk(tx_count == 5'(total), "R5 tx_count", tx_count, total);
    while (!req_ready && cyc < 400) begin
      if (done_ack) begin
        if (ack_c >= 0) chk(0, "R7 ack twice", cyc, ack_c);
        ack_c = cyc;
      end
      if (go) begin
        chk(ack_c >= 0 && !done_in, "R7 go order", {done_in, ack_c >= 0}, 1);
        go_c = cyc; gos++;
      end
      if (out_valid && first_c < 0) begin
        first_c = cyc;
        chk(go_c >= 0 && first_c == go_c + dly + 1, "R8 start delay",
            first_c - go_c, dly + 1);
      end
      if (out_valid) begin
        if (held) chk(out_data == held_d, "R11 hold", out_data, held_d);
        if (out_ready) begin
          logic [7:0] e = exp_byte(nb, cmd, ae, len, pay);
          chk(out_data == e, byte_tag(nb, len, i2c), out_data, e);
          nb++; held = 0;
        end else begin
          held = 1; held_d = out_data;
        end
      end else if (held) begin
        chk(0, "R11 valid dropped", 0, 1); held = 0;
      end
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (done_in && ack_c >= 0 && cyc >= ack_c + hold) done_in = 0;
      #1; cyc++;
    end
    chk(req_ready == 1, "R10 ready after last byte", req_ready, 1);
    chk(nb == total, wr ? "R4/R5 byte count" : "R3/R5 byte count", nb, total);
    chk(gos == 1, "R7 one go", gos, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_a0c1));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(req_ready && !out_valid && !go && !err && !done_ack, "R10 reset state",
        {req_ready, out_valid, go, err, done_ack}, 5'b10000);

    run_req(4'h8, 20'h5A3C1, 0, 1, 0, 0, {4{32'h1122_3344}}, 0, 0);
    run_req(4'h9, 20'hFEDCB, 5, 0, 0, 2, {4{32'hdead_beef}}, 1, 1);
    run_req(4'h8, 20'h00100, 1, 1, 0, 0, 128'h00AB, 0, 0);
    run_req(4'h8, 20'h12345, 16, 1, 0, 1, {32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100}, 0, 1);
    run_req(4'h9, 20'h00000, 17, 1, 0, 0, 0, 0, 0);
    run_req(4'h8, 20'h00000, 31, 0, 0, 0, 0, 0, 0);
    run_req(4'h0, 20'h000A0, 2, 1, 1, 0, 128'hC3_5A, 0, 0);
    run_req(4'h5, 20'h000A1, 3, 0, 1, 3, 0, 2, 1);
    run_req(4'h4, 20'h0ABCD, 4, 1, 0, 20, {4{32'h9876_5432}}, 0, 0);
    run_req(4'h8, 20'h33333, 2, 1, 0, 0, 128'h7788, 5, 1);

    for (int n = 0; n < 60; n++) begin
      int len = ($urandom % 8 == 0) ? 17 + $urandom % 15 : $urandom % 17;
      run_req(4'($urandom), 20'($urandom), len, 1'($urandom), 1'($urandom),
              $urandom % 6, {$urandom, $urandom, $urandom, $urandom},
              $urandom % 4, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule